// File: doc/BRIEF.md
# Segmented Address Prefetch Unit

This block forms 20-bit physical addresses from a 16-bit segment base and a 16-bit offset, and keeps a short first-in-first-out queue of instruction bytes ahead of the consumer. It holds four segment registers and an instruction offset. Whenever the queue has room, it sends word fetch requests to a simple memory port, placing each returned byte in the queue. An execution-side consumer takes bytes from the queue through a valid/ready handshake. Fetching and consumption overlap, so the consumer usually finds its next byte waiting.

A redirect input models a control transfer. It empties the queue at once, loads a new instruction offset and drops any fetch that is still outstanding. A separate combinational data-address port resolves an operand offset against a segment. That segment is chosen from the access kind and an optional override, and the port reports the 2-bit code of the segment it used. The fetch port reports the code segment in the same coding.

Top module: `seg_prefetch_unit`

## Requirements
- R1: A physical address equals the 16-bit segment value times 16 plus the 16-bit offset, kept modulo 2^20 with the carry out of bit 19 dropped. For example, segment 2000h with offset 0050h gives 20050h, and segment FFFFh with offset 0010h gives 00000h. The fetch offset itself wraps modulo 2^16.
- R2: Segment codes are 00 extra, 01 stack, 10 code and 11 data. The segment write select uses this coding, and so do both reported segment outputs. `mem_seg` is always 10.
- R3: The data port picks its default segment from `dacc_kind`: 00 data segment, 01 stack segment, 10 string destination (extra segment), 11 code segment. When `dacc_ovr_en` is high, `dacc_ovr_seg` replaces the default for every kind except string destination, which always uses the extra segment.
- R4: A fetch request carries the physical address of code segment:offset with bit 0 forced to 0, so each request names an aligned 16-bit word.
- R5: `mem_req` is high only when no fetch is outstanding and at least 2 queue slots are free. A request is accepted on a cycle where `mem_req` and `mem_gnt` are both high. Its data comes back on a later cycle with `mem_rvalid` high.
- R6: Returned words are little-endian (`mem_rdata[7:0]` is the even address). For an even offset both bytes are queued, low byte first. For an odd offset only `mem_rdata[15:8]` is queued. The fetch offset advances by the number of bytes queued.
- R7: The queue holds up to 6 bytes and delivers them in the order they were queued. `pop_valid` is low while the queue is empty. The head byte stays stable while it is not taken, and a byte is removed on a cycle where `pop_valid` and `pop_ready` are both high.
- R8: A cycle with `flush` high does three things: the queue is empty on the next cycle, the fetch offset becomes `flush_ip`, and the data of any fetch accepted before or during that cycle is discarded. Later bytes come from code segment:`flush_ip` onward.
- R9: After reset the queue is empty, no fetch is outstanding, the code segment holds FFFFh, the other segments hold 0000h, and the fetch offset is 0000h. The first request therefore names FFFF0h.
- R10: Fetching continues while the consumer pops, so a stream longer than the queue flows through without any flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Write one segment register |
| seg_wr_sel | input | 2 | Segment code of the register written |
| seg_wr_data | input | 16 | New segment value |
| flush | input | 1 | Redirect: empty queue, load new offset |
| flush_ip | input | 16 | New instruction offset on redirect |
| mem_req | output | 1 | Fetch request |
| mem_addr | output | 20 | Word-aligned physical fetch address |
| mem_seg | output | 2 | Segment code used by the fetch |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Fetch data returned this cycle |
| mem_rdata | input | 16 | Returned word, low byte at even address |
| pop_valid | output | 1 | Queue head byte is valid |
| pop_ready | input | 1 | Consumer takes the head byte |
| pop_data | output | 8 | Queue head byte |
| dacc_kind | input | 2 | Data access kind selecting the default segment |
| dacc_ovr_en | input | 1 | Apply segment override |
| dacc_ovr_seg | input | 2 | Override segment code |
| dacc_off | input | 16 | Data access offset |
| dacc_addr | output | 20 | Data access physical address |
| dacc_seg | output | 2 | Segment code used by the data access |

## Verification
The assertions watch, on every cycle, four things: the fetch gate (room for two bytes, a single outstanding request), the queue occupancy bound, the holding of an untaken head byte, and that a redirect leaves the queue empty and the string destination pinned to the extra segment. Only the bench scenarios can show that the byte stream matches memory contents in order. The same goes for odd-offset entry fetching a single byte, for a stale response landing after a redirect leaving no trace, and for the address wrap at both the offset and the 20-bit boundary. The data port's segment choice and the arithmetic of all its override cases are likewise checked by direct stimulus.

// File: rtl/spu_pkg.sv
package spu_pkg;

    typedef enum logic [1:0] {
        SEG_ES = 2'b00,
        SEG_SS = 2'b01,
        SEG_CS = 2'b10,
        SEG_DS = 2'b11
    } seg_code_e;

    typedef enum logic [1:0] {
        ACC_DATA   = 2'b00,
        ACC_STACK  = 2'b01,
        ACC_STRDST = 2'b10,
        ACC_CODE   = 2'b11
    } acc_kind_e;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

endpackage

// File: rtl/spu_addr_gen.sv
module spu_addr_gen #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int ADDR_W = 20
) (
    input  logic [SEG_W-1:0]  seg_base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] phys
);
    localparam int SHIFT = ADDR_W - SEG_W;
    localparam int PAD   = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] base_shifted;
    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        base_shifted = {seg_base, {SHIFT{1'b0}}};
        off_ext      = {{PAD{1'b0}}, offset};
        // sum truncated to ADDR_W: carry beyond the top bit is dropped
        phys         = base_shifted + off_ext;
    end
endmodule

// File: rtl/spu_seg_file.sv
module spu_seg_file
    import spu_pkg::*;
#(
    parameter int              SEG_W  = 16,
    parameter logic [SEG_W-1:0] RST_CS = 'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [SEG_W-1:0] rd_val,
    output logic [SEG_W-1:0] cs_val
);
    localparam int NSEG = 4;

    typedef struct packed {
        logic [NSEG-1:0][SEG_W-1:0] seg;
    } sf_state_t;

    sf_state_t         st_d, st_q;
    logic [NSEG-1:0]   wr_hit;

    for (genvar g = 0; g < NSEG; g++) begin : g_hit
        assign wr_hit[g] = wr_en && (wr_sel == 2'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSEG; i++) begin
            if (wr_hit[i]) st_d.seg[i] = wr_data;
        end
        rd_val = st_q.seg[rd_sel];
        cs_val = st_q.seg[SEG_CS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q             <= '0;
            st_q.seg[SEG_CS] <= RST_CS;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spu_byte_queue.sv
module spu_byte_queue
    import spu_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [1:0]        push_n,
    input  logic [BYTE_W-1:0] push_b0,
    input  logic [BYTE_W-1:0] push_b1,
    input  logic              pop_ready,
    output logic              pop_valid,
    output logic [BYTE_W-1:0] pop_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [$clog2(DEPTH+1)-1:0] free
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [CNT_W-1:0]             cnt;
    } bq_state_t;

    bq_state_t st_d, st_q;
    logic      pop_fire;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d      = st_q;
        pop_valid = (st_q.cnt != '0);
        pop_data  = st_q.mem[st_q.rd];
        pop_fire  = pop_valid && pop_ready;
        count     = st_q.cnt;
        free      = CNT_W'(DEPTH) - st_q.cnt;

        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_n != 2'd0) begin
                st_d.mem[st_q.wr] = push_b0;
                st_d.wr           = ptr_inc(st_q.wr);
            end
            if (push_n == 2'd2) begin
                st_d.mem[ptr_inc(st_q.wr)] = push_b1;
                st_d.wr                    = ptr_inc(ptr_inc(st_q.wr));
            end
            if (pop_fire) begin
                st_d.rd = ptr_inc(st_q.rd);
            end
            st_d.cnt = st_q.cnt + CNT_W'(push_n) - CNT_W'(pop_fire);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spu_fetch_ctl.sv
module spu_fetch_ctl
    import spu_pkg::*;
#(
    parameter int              OFF_W  = 16,
    parameter int              CNT_W  = 3,
    parameter logic [OFF_W-1:0] RST_IP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [OFF_W-1:0]  flush_ip,
    input  logic [CNT_W-1:0]  q_free,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [OFF_W-1:0]  fetch_ip,
    output logic [1:0]        push_n,
    output logic [BYTE_W-1:0] push_b0,
    output logic [BYTE_W-1:0] push_b1
);
    typedef struct packed {
        logic [OFF_W-1:0] ip;
        logic             inflight;
        logic             stale;
        logic             odd;
    } fc_state_t;

    fc_state_t st_d, st_q;
    logic      issue;
    logic      take;
    logic      keep;

    always_comb begin
        st_d     = st_q;
        mem_req  = !st_q.inflight && (q_free >= CNT_W'(2));
        issue    = mem_req && mem_gnt;
        take     = st_q.inflight && mem_rvalid;
        keep     = take && !st_q.stale && !flush;
        fetch_ip = st_q.ip;

        push_n  = 2'd0;
        push_b0 = mem_rdata[BYTE_W-1:0];
        push_b1 = mem_rdata[WORD_W-1:BYTE_W];
        if (keep) begin
            if (st_q.odd) begin
                push_n  = 2'd1;
                push_b0 = mem_rdata[WORD_W-1:BYTE_W];
            end else begin
                push_n  = 2'd2;
            end
        end

        if (issue) begin
            st_d.inflight = 1'b1;
            st_d.odd      = st_q.ip[0];
        end else if (take) begin
            st_d.inflight = 1'b0;
        end

        if (flush) begin
            st_d.ip    = flush_ip;
            st_d.stale = st_d.inflight;
        end else begin
            st_d.ip = st_q.ip + OFF_W'(push_n);
            if (take) st_d.stale = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ip <= RST_IP;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/seg_prefetch_unit.sv
module seg_prefetch_unit
    import spu_pkg::*;
#(
    parameter int               SEG_W  = 16,
    parameter int               OFF_W  = 16,
    parameter int               ADDR_W = 20,
    parameter int               DEPTH  = 6,
    parameter logic [SEG_W-1:0] RST_CS = 'hFFFF,
    parameter logic [OFF_W-1:0] RST_IP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [1:0]        seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              flush,
    input  logic [OFF_W-1:0]  flush_ip,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_seg,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              pop_valid,
    input  logic              pop_ready,
    output logic [BYTE_W-1:0] pop_data,
    input  logic [1:0]        dacc_kind,
    input  logic              dacc_ovr_en,
    input  logic [1:0]        dacc_ovr_seg,
    input  logic [OFF_W-1:0]  dacc_off,
    output logic [ADDR_W-1:0] dacc_addr,
    output logic [1:0]        dacc_seg
);
    localparam int CNT_W = $clog2(DEPTH+1);

    seg_code_e         dflt_seg;
    seg_code_e         used_seg;
    logic [SEG_W-1:0]  data_seg_val;
    logic [SEG_W-1:0]  code_seg_val;
    logic [OFF_W-1:0]  fetch_ip;
    logic [ADDR_W-1:0] fetch_phys;
    logic [CNT_W-1:0]  q_count;
    logic [CNT_W-1:0]  q_free;
    logic [1:0]        push_n;
    logic [BYTE_W-1:0] push_b0;
    logic [BYTE_W-1:0] push_b1;

    always_comb begin
        unique case (acc_kind_e'(dacc_kind))
            ACC_DATA:   dflt_seg = SEG_DS;
            ACC_STACK:  dflt_seg = SEG_SS;
            ACC_STRDST: dflt_seg = SEG_ES;
            default:    dflt_seg = SEG_CS;
        endcase
        if (dacc_ovr_en && (acc_kind_e'(dacc_kind) != ACC_STRDST))
            used_seg = seg_code_e'(dacc_ovr_seg);
        else
            used_seg = dflt_seg;
        dacc_seg = used_seg;
        mem_seg  = SEG_CS;
        mem_addr = fetch_phys & ~ADDR_W'(1);
    end

    spu_seg_file #(
        .SEG_W  (SEG_W),
        .RST_CS (RST_CS)
    ) u_segs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .rd_sel  (used_seg),
        .rd_val  (data_seg_val),
        .cs_val  (code_seg_val)
    );

    spu_addr_gen #(
        .SEG_W (SEG_W), .OFF_W (OFF_W), .ADDR_W (ADDR_W)
    ) u_agen_data (
        .seg_base (data_seg_val),
        .offset   (dacc_off),
        .phys     (dacc_addr)
    );

    spu_addr_gen #(
        .SEG_W (SEG_W), .OFF_W (OFF_W), .ADDR_W (ADDR_W)
    ) u_agen_fetch (
        .seg_base (code_seg_val),
        .offset   (fetch_ip),
        .phys     (fetch_phys)
    );

    spu_fetch_ctl #(
        .OFF_W  (OFF_W),
        .CNT_W  (CNT_W),
        .RST_IP (RST_IP)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .flush_ip   (flush_ip),
        .q_free     (q_free),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .fetch_ip   (fetch_ip),
        .push_n     (push_n),
        .push_b0    (push_b0),
        .push_b1    (push_b1)
    );

    spu_byte_queue #(
        .DEPTH (DEPTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_n    (push_n),
        .push_b0   (push_b0),
        .push_b1   (push_b1),
        .pop_ready (pop_ready),
        .pop_valid (pop_valid),
        .pop_data  (pop_data),
        .count     (q_count),
        .free      (q_free)
    );
endmodule

// File: rtl/spu_checker.sv
module spu_checker #(
    parameter int DEPTH = 6,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             mem_req,
    input logic             mem_gnt,
    input logic             pop_valid,
    input logic             pop_ready,
    input logic [7:0]       pop_data,
    input logic [1:0]       dacc_kind,
    input logic [1:0]       dacc_seg,
    input logic [CNT_W-1:0] q_count
);
    AST_REQ_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (q_count <= CNT_W'(DEPTH-2)));                        // R5

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req);                               // R5

    AST_OCCUPANCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));                                        // R7

    AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !pop_ready && !flush) |=> (pop_valid && $stable(pop_data))); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!pop_valid && (q_count == '0)));                        // R8

    AST_STRDST_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (dacc_kind == 2'b10) |-> (dacc_seg == 2'b00));                    // R3
endmodule

bind seg_prefetch_unit spu_checker #(
    .DEPTH (DEPTH),
    .CNT_W ($clog2(DEPTH+1))
) u_spu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .pop_valid (pop_valid),
    .pop_ready (pop_ready),
    .pop_data  (pop_data),
    .dacc_kind (dacc_kind),
    .dacc_seg  (dacc_seg),
    .q_count   (q_count)
);

// File: tb/seg_prefetch_unit_test.sv
module seg_prefetch_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = 2'b00;
    logic [15:0] seg_wr_data = 16'h0;
    logic        flush = 1'b0;
    logic [15:0] flush_ip = 16'h0;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic [1:0]  mem_seg;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = 16'h0;
    logic        pop_valid;
    logic        pop_ready = 1'b0;
    logic [7:0]  pop_data;
    logic [1:0]  dacc_kind = 2'b00;
    logic        dacc_ovr_en = 1'b0;
    logic [1:0]  dacc_ovr_seg = 2'b00;
    logic [15:0] dacc_off = 16'h0;
    logic [19:0] dacc_addr;
    logic [1:0]  dacc_seg;

    int          checks = 0;
    int          failures = 0;
    int          lat = 1;
    bit          done = 1'b0;
    logic [15:0] exp_cs = 16'hFFFF;
    logic [15:0] exp_ip = 16'h0;

    always #2 clk = ~clk;

    seg_prefetch_unit uut (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .flush(flush), .flush_ip(flush_ip),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_seg(mem_seg),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
        .dacc_kind(dacc_kind), .dacc_ovr_en(dacc_ovr_en), .dacc_ovr_seg(dacc_ovr_seg),
        .dacc_off(dacc_off), .dacc_addr(dacc_addr), .dacc_seg(dacc_seg)
    );

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    function automatic logic [7:0] mbyte(input logic [19:0] a);
        return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic [15:0] mword(input logic [19:0] a);
        return {mbyte(a | 20'h1), mbyte(a & ~20'h1)};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic responder();
        logic        pend = 1'b0;
        logic        cap;
        logic [19:0] cap_a;
        logic [19:0] a = '0;
        int          cnt = 0;
        forever begin
            @(posedge clk);
            cap   = mem_req && mem_gnt && rst_n;
            cap_a = mem_addr;
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (cap && !pend) begin
                pend = 1'b1;
                a    = cap_a;
                cnt  = lat;
            end
            if (pend) begin
                cnt--;
                if (cnt <= 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mword(a);
                    pend       = 1'b0;
                end
            end
        end
    endtask

    task automatic seg_write(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
        @(negedge clk);
        seg_wr_en = 1'b0;
        if (sel == 2'b10) exp_cs = val;
    endtask

    task automatic do_flush(input logic [15:0] ip);
        @(negedge clk);
        pop_ready = 1'b0;
        flush = 1'b1; flush_ip = ip;
        @(negedge clk);
        flush = 1'b0;
        exp_ip = ip;
    endtask

    task automatic pop_n(input int n, input string req);
        int got = 0;
        int cyc = 0;
        while (got < n && cyc < 2000) begin
            @(negedge clk);
            if (pop_valid) begin
                chk(req, "stream byte", pop_data, mbyte(phys(exp_cs, exp_ip)));
                exp_ip++;
                got++;
                pop_ready = 1'b1;
            end else begin
                pop_ready = 1'b0;
            end
            cyc++;
        end
        @(negedge clk);
        pop_ready = 1'b0;
        chk(req, "bytes popped", got, n);
    endtask

    task automatic dacc(input logic [1:0] kind, input logic oen, input logic [1:0] oseg,
                        input logic [15:0] off, input logic [19:0] ea,
                        input logic [1:0] es, input string req);
        @(negedge clk);
        dacc_kind = kind; dacc_ovr_en = oen; dacc_ovr_seg = oseg; dacc_off = off;
        #1;
        chk(req, "data address", dacc_addr, ea);
        chk(req, "data segment code", dacc_seg, es);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R9", "pop_valid after reset", pop_valid, 0);
        chk("R9", "mem_req after reset", mem_req, 1);
        chk("R9", "first fetch address", mem_addr, 20'hFFFF0);
        chk("R2", "fetch segment code", mem_seg, 2'b10);
    endtask

    task automatic test_data_port();
        seg_write(2'b11, 16'h2000);
        seg_write(2'b01, 16'hFFFF);
        seg_write(2'b00, 16'h3000);
        seg_write(2'b10, 16'h1234);
        dacc(2'b00, 1'b0, 2'b00, 16'h0050, 20'h20050, 2'b11, "R1");
        dacc(2'b01, 1'b0, 2'b00, 16'h0010, 20'h00000, 2'b01, "R1");
        dacc(2'b11, 1'b0, 2'b00, 16'h0000, 20'h12340, 2'b10, "R2");
        dacc(2'b00, 1'b1, 2'b00, 16'h0001, 20'h30001, 2'b00, "R3");
        dacc(2'b10, 1'b1, 2'b10, 16'h0002, 20'h30002, 2'b00, "R3");
        dacc(2'b01, 1'b1, 2'b11, 16'hFFFF, 20'h2FFFF, 2'b11, "R3");
    endtask

    task automatic test_stream();
        lat = 1;
        do_flush(16'h0100);
        chk("R4", "request address after redirect", mem_addr, phys(exp_cs, 16'h0100));
        chk("R2", "fetch segment code", mem_seg, 2'b10);
        mem_gnt = 1'b1;
        pop_n(14, "R10");
    endtask

    task automatic test_odd_entry();
        mem_gnt = 1'b0;
        do_flush(16'h0101);
        chk("R4", "aligned request for odd offset", mem_addr, phys(exp_cs, 16'h0100));
        mem_gnt = 1'b1;
        pop_n(5, "R6");
    endtask

    task automatic test_fill();
        int got = 0;
        mem_gnt = 1'b0;
        do_flush(16'h0300);
        mem_gnt = 1'b1;
        repeat (30) @(negedge clk);
        chk("R5", "no request with queue full", mem_req, 0);
        chk("R7", "valid with queue full", pop_valid, 1);
        pop_n(1, "R7");
        chk("R5", "no request with one free slot", mem_req, 0);
        mem_gnt = 1'b0;
        pop_n(1, "R7");
        chk("R5", "request with two free slots", mem_req, 1);
        repeat (20) begin
            @(negedge clk);
            if (pop_valid) begin
                chk("R7", "drain byte", pop_data, mbyte(phys(exp_cs, exp_ip)));
                exp_ip++;
                got++;
                pop_ready = 1'b1;
            end else begin
                pop_ready = 1'b0;
            end
        end
        pop_ready = 1'b0;
        chk("R7", "bytes left from a full queue after two pops", got, 4);
        chk("R7", "valid low when empty", pop_valid, 0);
    endtask

    task automatic test_flush_inflight();
        mem_gnt = 1'b0;
        do_flush(16'h0400);
        lat = 6;
        mem_gnt = 1'b1;
        do @(negedge clk); while (!mem_req);
        @(negedge clk);
        flush = 1'b1; flush_ip = 16'h0500;
        @(negedge clk);
        flush = 1'b0;
        exp_ip = 16'h0500;
        chk("R8", "queue empty after redirect", pop_valid, 0);
        pop_n(6, "R8");
        lat = 1;
        repeat (30) @(negedge clk);
        chk("R8", "queue full before redirect", pop_valid, 1);
        do_flush(16'h0600);
        chk("R8", "full queue emptied by redirect", pop_valid, 0);
        pop_n(4, "R8");
    endtask

    task automatic test_wrap();
        seg_write(2'b10, 16'hFFFF);
        do_flush(16'hFFFE);
        pop_n(4, "R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        fork
            responder();
        join_none
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_data_port();
        test_stream();
        test_odd_entry();
        test_fill();
        test_flush_inflight();
        test_wrap();
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule